// File: doc/BRIEF.md
# Vector Unzip Permutation Unit

This block separates alternate elements out of a pair of vectors. The two source vectors, each `VL` bits wide, are joined into one double-width value. The second source forms the upper half and the first source forms the lower half. The block then gathers every second element of that value into a single `VL`-bit destination, beginning at element 0 (even phase) or at element 1 (odd phase). The element width is chosen at run time with a 2-bit code and can be 8, 16, 32 or 64 bits.

An operation is accepted on any cycle in which `in_valid` is high. The operands, the size code and the phase select are all sampled together on that edge. The result is registered and appears on the next cycle, flagged by `out_valid`. The operation has no predicate, so every destination element is rewritten on each accepted operation. The vector length is an elaboration parameter. It must be a multiple of 128 between 128 and 2048, which keeps the element count whole for every size.

Top module: `vec_unzip_unit`

## Requirements
- R1: With size code 0 (8-bit elements), destination byte e equals byte 2e+p of the joined value {src_b, src_a}, where p is `odd_sel`.
- R2: With size code 1 (16-bit elements), destination halfword e equals halfword 2e+p of {src_b, src_a}.
- R3: With size code 2 (32-bit elements), destination word e equals word 2e+p of {src_b, src_a}.
- R4: With size code 3 (64-bit elements), destination doubleword e equals doubleword 2e+p of {src_b, src_a}.
- R5: `src_a` supplies the lower half of the joined value and `src_b` the upper half. Under odd phase the top byte of `dst` is therefore the top byte of `src_b`, and under even phase the lower half of `dst` comes only from `src_a`.
- R6: `odd_sel`=0 selects the even-indexed elements, so the bottom byte of `dst` is the bottom byte of `src_a`. `odd_sel`=1 selects the odd-indexed elements.
- R7: `out_valid` is high in the cycle after an edge that samples `in_valid` high, and low in the cycle after an edge that samples `in_valid` low.
- R8: A synchronous active-high `rst` clears `out_valid` and `dst` to zero on the next edge, and takes priority over `in_valid`.
- R9: While `in_valid` is low, `dst` keeps the last result.
- R10: The size code and `odd_sel` act only when sampled together with `in_valid`. Changing them on idle cycles leaves `dst` unchanged, and back-to-back operations may each use a different size and phase.
- R11: When both operands carry the same vector, the result still follows the index rule of R1 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept an operation this edge |
| src_a | input | VL | First source vector, lower half of the joined value |
| src_b | input | VL | Second source vector, upper half of the joined value |
| size_code | input | 2 | Element width: 0=8, 1=16, 2=32, 3=64 bits |
| odd_sel | input | 1 | 0 = even elements, 1 = odd elements |
| out_valid | output | 1 | Result valid |
| dst | output | VL | Destination vector |

## Verification
Several properties are checked on every cycle:
- the one-cycle valid latency;
- reset clearing the output;
- the result holding while idle;
- the two end elements that do not depend on size: the bottom byte under even phase and the top byte under odd phase.

The full index mapping for each element size and phase cannot be seen by those checks. Neither can ignoring size and phase changes on idle cycles, or the operation on identical operands. Those need the bench's scenarios, which compare every result against an independent model of the index formula.

// File: rtl/uzp_pkg.sv
package uzp_pkg;
   localparam int NUM_SIZES = 4;
   localparam int MIN_ELEM  = 8;

   typedef enum logic [1:0] {
      ESZ_BYTE = 2'd0,
      ESZ_HALF = 2'd1,
      ESZ_WORD = 2'd2,
      ESZ_DBL  = 2'd3
   } esz_e;

   function automatic int elem_bits(input int code);
      return MIN_ELEM << code;
   endfunction
endpackage

// File: rtl/uzp_size_net.sv
// Fixed-width unzip network: one element size, phase picked at run time.
module uzp_size_net #(
   parameter int VL  = 256,
   parameter int ESZ = 8
) (
   input  logic [VL-1:0] a,
   input  logic [VL-1:0] b,
   input  logic          odd,
   output logic [VL-1:0] y
);
   localparam int NELEM = VL / ESZ;

   logic [2*VL-1:0] joined;
   assign joined = {b, a};

   for (genvar e = 0; e < NELEM; e++) begin : g_elem
      logic [ESZ-1:0] ev_el;
      logic [ESZ-1:0] od_el;
      assign ev_el = joined[(2*e)*ESZ +: ESZ];
      assign od_el = joined[(2*e+1)*ESZ +: ESZ];
      assign y[e*ESZ +: ESZ] = odd ? od_el : ev_el;
   end
endmodule

// File: rtl/uzp_out_stage.sv
// Result register with valid flag; synchronous reset.
module uzp_out_stage #(
   parameter int W = 256
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         vld
);
   always_ff @(posedge clk) begin
      if (rst) begin
         vld <= 1'b0;
         q   <= '0;
      end else begin
         vld <= ld;
         if (ld) q <= d;
      end
   end
endmodule

// File: rtl/vec_unzip_unit.sv
module vec_unzip_unit #(
   parameter int VL = 256
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [VL-1:0] src_a,
   input  logic [VL-1:0] src_b,
   input  logic [1:0]    size_code,
   input  logic          odd_sel,
   output logic          out_valid,
   output logic [VL-1:0] dst
);
   import uzp_pkg::*;

   if (VL % 128 != 0) begin : g_bad_mult
      $error("vec_unzip_unit: VL must be a multiple of 128");
   end
   if (VL < 128 || VL > 2048) begin : g_bad_range
      $error("vec_unzip_unit: VL must lie in 128..2048");
   end

   logic [VL-1:0] net_y [NUM_SIZES];
   logic [VL-1:0] sel_y;
   esz_e          esz;

   assign esz = esz_e'(size_code);

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_net
      uzp_size_net #(
         .VL (VL),
         .ESZ(elem_bits(s))
      ) u_net (
         .a  (src_a),
         .b  (src_b),
         .odd(odd_sel),
         .y  (net_y[s])
      );
   end

   always_comb begin
      unique case (esz)
         ESZ_BYTE: sel_y = net_y[0];
         ESZ_HALF: sel_y = net_y[1];
         ESZ_WORD: sel_y = net_y[2];
         default:  sel_y = net_y[3];
      endcase
   end

   uzp_out_stage #(
      .W(VL)
   ) u_stage (
      .clk(clk),
      .rst(rst),
      .ld (in_valid),
      .d  (sel_y),
      .q  (dst),
      .vld(out_valid)
   );
endmodule

// File: rtl/vec_unzip_chk.sv
module vec_unzip_chk #(
   parameter int VL = 256
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic [VL-1:0] src_a,
   input logic [VL-1:0] src_b,
   input logic [1:0]    size_code,
   input logic          odd_sel,
   input logic          out_valid,
   input logic [VL-1:0] dst
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R7
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid); // R7
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!out_valid && dst == '0)); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(dst)); // R9
   AST_EVEN_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !odd_sel) |=> dst[7:0] == $past(src_a[7:0])); // R6
   AST_ODD_TOP_BYTE: assert property (@(posedge clk) disable iff (rst)
      (in_valid && odd_sel) |=> dst[VL-1 -: 8] == $past(src_b[VL-1 -: 8])); // R5
endmodule

bind vec_unzip_unit vec_unzip_chk #(.VL(VL)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
   .size_code(size_code), .odd_sel(odd_sel), .out_valid(out_valid), .dst(dst)
);

// File: tb/tb_vec_unzip_unit.sv
module tb_vec_unzip_unit;
   localparam int VL = 256;

   logic          clk = 1'b0;
   logic          rst;
   logic          in_valid;
   logic [VL-1:0] src_a, src_b;
   logic [1:0]    size_code;
   logic          odd_sel;
   logic          out_valid;
   logic [VL-1:0] dst;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [VL-1:0] exp_q [$];
   string         tag_q [$];
   logic [VL-1:0] last_exp;

   always #4 clk = ~clk;

   vec_unzip_unit #(.VL(VL)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
      .size_code(size_code), .odd_sel(odd_sel), .out_valid(out_valid), .dst(dst)
   );

   function automatic logic [VL-1:0] rand_vec();
      logic [VL-1:0] v;
      for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   function automatic logic [VL-1:0] ref_unzip(logic [VL-1:0] a, logic [VL-1:0] b,
                                               int sz, int p);
      logic [2*VL-1:0] c;
      logic [VL-1:0]   r;
      int w;
      c = {b, a};
      w = 8 << sz;
      r = '0;
      for (int e = 0; e < VL / w; e++)
         for (int i = 0; i < w; i++)
            r[e*w + i] = c[(2*e + p)*w + i];
      return r;
   endfunction

   task automatic check(string tag, logic [VL-1:0] act, logic [VL-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(logic [VL-1:0] a, logic [VL-1:0] b, int sz, int p, string tag);
      @(negedge clk);
      in_valid  = 1'b1;
      src_a     = a;
      src_b     = b;
      size_code = 2'(sz);
      odd_sel   = 1'(p);
      last_exp  = ref_unzip(a, b, sz, p);
      exp_q.push_back(last_exp);
      tag_q.push_back(tag);
   endtask

   // idle cycle with scrambled inputs, then confirm nothing moved
   task automatic idle_check(string tag);
      @(negedge clk);
      in_valid  = 1'b0;
      src_a     = rand_vec();
      src_b     = rand_vec();
      size_code = size_code + 2'd1;
      odd_sel   = ~odd_sel;
      @(negedge clk);
      check("R7 idle out_valid", {{(VL-1){1'b0}}, out_valid}, '0);
      check(tag, dst, last_exp);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst === 1'b0 && out_valid === 1'b1) begin
         if (exp_q.size() == 0) begin
            check("R7 unexpected out_valid", '1, '0);
         end else begin
            check(tag_q.pop_front(), dst, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      string tg;
      rst = 1'b1; in_valid = 1'b0; src_a = '0; src_b = '0;
      size_code = 2'd0; odd_sel = 1'b0;
      repeat (3) @(negedge clk);
      check("R8 reset out_valid", {{(VL-1){1'b0}}, out_valid}, '0);
      check("R8 reset dst", dst, '0);
      rst = 1'b0;

      // every size, both phases, random data
      for (int sz = 0; sz < 4; sz++) begin
         for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 3; k++) begin
               tg = (sz == 0) ? "R1" : (sz == 1) ? "R2" : (sz == 2) ? "R3" : "R4";
               tg = {tg, p ? " odd R6" : " even R6"};
               drive(rand_vec(), rand_vec(), sz, p, tg);
            end
         end
      end
      idle_check("R9 hold after stream");

      // operand placement: zeros low, ones high
      for (int sz = 0; sz < 4; sz++) begin
         drive('0, '1, sz, 0, "R5 even placement");
         drive('0, '1, sz, 1, "R5 odd placement");
      end
      drive({VL/8{8'hA5}}, {VL/8{8'h3C}}, 0, 1, "R5 byte pattern");

      // identical operands
      for (int sz = 0; sz < 4; sz++) begin
         logic [VL-1:0] v;
         v = rand_vec();
         drive(v, v, sz, 0, "R11 same even");
         drive(v, v, sz, 1, "R11 same odd");
      end

      // size/phase changes while idle do not disturb the result
      idle_check("R10 idle size/phase change");
      idle_check("R9 second idle hold");

      // back-to-back with size and phase changing every op
      for (int k = 0; k < 16; k++)
         drive(rand_vec(), rand_vec(), k % 4, (k / 4) % 2, "R10 back-to-back");
      idle_check("R9 hold after back-to-back");

      // reset wins over a simultaneous valid
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b1; src_a = rand_vec(); src_b = rand_vec();
      @(negedge clk);
      check("R8 reset priority out_valid", {{(VL-1){1'b0}}, out_valid}, '0);
      check("R8 reset priority dst", dst, '0);
      rst = 1'b0; in_valid = 1'b0;
      last_exp = '0;
      idle_check("R9 hold after reset");

      drive(rand_vec(), rand_vec(), 3, 1, "R4 after reset");
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      check("R7 queue drained", VL'(exp_q.size()), '0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule